// File: doc/BRIEF.md
# PWM Fault Trip Action Unit

This block sits between a PWM generator and the two output pins of one PWM channel, called output A and output B. It watches three external fault inputs and two single-cycle software strobes. From these it keeps two trip states. A latched trip stays active until it is cleared explicitly. A cycle-limited trip clears itself at the next timer-zero strobe.

While a trip is active, each output is overridden by a programmed 2-bit action. The action is chosen by which trip is active and by the timer's count direction at that moment. A 24-bit configuration word holds the per-source enables and the eight override actions. The word is written through a write-enable and 32-bit data port, and it is always visible on a read-back port.

Fault inputs are asynchronous and pass through a two-flop synchroniser. The software strobes are already synchronous to the clock.

Top module: `pwm_trip_unit`

## Requirements
- R1: Configuration bit 0 lets the cycle-limited software strobe set the cycle-limited trip. Bits 1, 2 and 3 let fault inputs 2, 1 and 0 set it. A source whose bit is 0 has no effect on the outputs.
- R2: Configuration bit 4 lets the latched software strobe set the latched trip. Bits 5, 6 and 7 let fault inputs 2, 1 and 0 set it. A source whose bit is 0 has no effect on the outputs.
- R3: Action codes are 0 = pass the input through, 1 = drive 0, 2 = drive 1 and 3 = invert the input. Inversion is combinational and lasts as long as the trip is active.
- R4: Output A takes its actions from these bits: 9:8 for cycle-limited while counting down, 11:10 for cycle-limited while counting up, 13:12 for latched while counting down, and 15:14 for latched while counting up.
- R5: Output B takes its actions from bits 17:16, 19:18, 21:20 and 23:22, with the same meaning as R4 in the same order.
- R6: The direction used to select an action is the live count-direction input. When that input changes while a trip is active, the action changes in the same cycle.
- R7: After reset the configuration word is 0, no trip is active, and each output equals its PWM input.
- R8: The latched trip stays active through timer-zero strobes. A clear pulse ends it, unless an enabled latched source is asserted in the same cycle; in that case the trip stays set.
- R9: The cycle-limited trip ends at a timer-zero strobe, unless an enabled cycle-limited source is asserted in the same cycle.
- R10: When both trips are active, the latched trip's action is applied and the cycle-limited action is ignored.
- R11: A software strobe affects the outputs immediately after the clock edge that samples it. A fault input affects the outputs only after the third rising edge at which it is held high.
- R12: A configuration write stores data bits 23:0 at the clock edge. The read-back port shows the stored word with bits 31:24 reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read-back |
| pwmInA | input | 1 | Raw PWM level for output A |
| pwmInB | input | 1 | Raw PWM level for output B |
| cntUp | input | 1 | Timer count direction, 1 = counting up |
| tezStrobe | input | 1 | Timer-equals-zero strobe |
| faultIn | input | 3 | Asynchronous fault inputs, index 0 to 2 |
| swCbcStrobe | input | 1 | Software strobe for the cycle-limited trip |
| swOstStrobe | input | 1 | Software strobe for the latched trip |
| ostClear | input | 1 | Clear pulse for the latched trip |
| pwmOutA | output | 1 | Output A after trip override |
| pwmOutB | output | 1 | Output B after trip override |

## Verification
A wrong trip state shows up on the pin outputs in the cycle right after the edge that should have set or cleared it. The outputs are combinational from the two trip flops. The bench therefore loads every action code into every slot, with a complementary code on output B. Any wrong trip bit, field slice or direction choice then gives at least one wrong pin value.

A synchroniser with the wrong depth shows up at the fault inputs. The trip appears one edge early or late, and the bench checks the output edge by edge to catch this. A swapped fault-to-enable mapping lets the wrong fault trip the outputs, so each enable bit is tested against all three faults.

// File: rtl/pwm_trip_pkg.sv
`timescale 1ns/1ps
package pwm_trip_pkg;

  typedef enum logic [1:0] {
    ACT_PASS   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_INVERT = 2'd3
  } tripAct_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ostOn;
    logic cbcOn;
    logic cntUp;
  } tripCtl_t;

  localparam int ACT_BITS     = 2;
  localparam int SLOTS_PER_OUT = 4;

endpackage

// File: rtl/trip_ctrl.sv
`timescale 1ns/1ps
module trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int NUM_FAULTS  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_W-1:0]      cfgWrData,
  output logic [CFG_W-1:0]      cfgQ,
  input  logic                  cntUp,
  input  logic                  tezStrobe,
  input  logic [NUM_FAULTS-1:0] faultIn,
  input  logic                  swCbcStrobe,
  input  logic                  swOstStrobe,
  input  logic                  ostClear,
  output tripCtl_t              ctl
);

  localparam int OST_BASE = NUM_FAULTS + 1;

  logic [SYNC_STAGES-1:0][NUM_FAULTS-1:0] syncQ;
  logic [NUM_FAULTS-1:0] faultS;
  logic cbcSrc, ostSrc;
  logic cbcOn, ostOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgWrData;
  end

  // fault synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else begin
      syncQ[0] <= faultIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign faultS = syncQ[SYNC_STAGES-1];

  // enable bit (base+1+i) gates fault (NUM_FAULTS-1-i)
  always_comb begin
    cbcSrc = cfgQ[0] & swCbcStrobe;
    ostSrc = cfgQ[OST_BASE] & swOstStrobe;
    for (int i = 0; i < NUM_FAULTS; i++) begin
      cbcSrc = cbcSrc | (cfgQ[1 + i] & faultS[NUM_FAULTS-1-i]);
      ostSrc = ostSrc | (cfgQ[OST_BASE + 1 + i] & faultS[NUM_FAULTS-1-i]);
    end
  end

  // set wins over clear for both trips
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbcOn <= 1'b0;
      ostOn <= 1'b0;
    end else begin
      if (cbcSrc) cbcOn <= 1'b1;
      else if (tezStrobe) cbcOn <= 1'b0;
      if (ostSrc) ostOn <= 1'b1;
      else if (ostClear) ostOn <= 1'b0;
    end
  end

  assign ctl = '{ostOn: ostOn, cbcOn: cbcOn, cntUp: cntUp};

endmodule

// File: rtl/trip_datapath.sv
`timescale 1ns/1ps
module trip_datapath
  import pwm_trip_pkg::*;
#(
  parameter int NUM_OUTS = 2,
  localparam int OUT_W   = ACT_BITS * SLOTS_PER_OUT
) (
  input  tripCtl_t                ctl,
  input  logic [OUT_W*NUM_OUTS-1:0] actCfg,
  input  logic [NUM_OUTS-1:0]     pwmIn,
  output logic [NUM_OUTS-1:0]     pwmOut
);

  // slot order: cbc down, cbc up, ost down, ost up
  logic [1:0] slotSel;
  logic       tripOn;

  always_comb begin
    slotSel = {ctl.ostOn, ctl.cntUp};
    tripOn  = ctl.ostOn | ctl.cbcOn;
  end

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
    logic [OUT_W-1:0] slice;
    tripAct_e act;
    assign slice = actCfg[g*OUT_W +: OUT_W];
    always_comb begin
      act = tripOn ? tripAct_e'(slice[slotSel*ACT_BITS +: ACT_BITS]) : ACT_PASS;
      unique case (act)
        ACT_PASS:   pwmOut[g] = pwmIn[g];
        ACT_LOW:    pwmOut[g] = 1'b0;
        ACT_HIGH:   pwmOut[g] = 1'b1;
        ACT_INVERT: pwmOut[g] = ~pwmIn[g];
        default:    pwmOut[g] = pwmIn[g];
      endcase
    end
  end

endmodule

// File: rtl/pwm_trip_unit.sv
`timescale 1ns/1ps
module pwm_trip_unit
  import pwm_trip_pkg::*;
#(
  parameter int NUM_FAULTS  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  localparam int NUM_OUTS   = 2,
  localparam int CFG_W      = 2 * (NUM_FAULTS + 1) + NUM_OUTS * ACT_BITS * SLOTS_PER_OUT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [DATA_W-1:0]     cfgWrData,
  output logic [DATA_W-1:0]     cfgRdData,
  input  logic                  pwmInA,
  input  logic                  pwmInB,
  input  logic                  cntUp,
  input  logic                  tezStrobe,
  input  logic [NUM_FAULTS-1:0] faultIn,
  input  logic                  swCbcStrobe,
  input  logic                  swOstStrobe,
  input  logic                  ostClear,
  output logic                  pwmOutA,
  output logic                  pwmOutB
);

  localparam int ACT_BASE = 2 * (NUM_FAULTS + 1);

  logic [CFG_W-1:0] cfgQ;
  tripCtl_t         tripCtl;
  logic [NUM_OUTS-1:0] pwmOutV;
  logic             unusedWrHi;

  assign unusedWrHi = ^cfgWrData[DATA_W-1:CFG_W];

  trip_ctrl #(
    .NUM_FAULTS(NUM_FAULTS), .SYNC_STAGES(SYNC_STAGES), .CFG_W(CFG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData[CFG_W-1:0]),
    .cfgQ(cfgQ), .cntUp(cntUp), .tezStrobe(tezStrobe), .faultIn(faultIn),
    .swCbcStrobe(swCbcStrobe), .swOstStrobe(swOstStrobe), .ostClear(ostClear),
    .ctl(tripCtl)
  );

  trip_datapath #(.NUM_OUTS(NUM_OUTS)) u_dp (
    .ctl(tripCtl), .actCfg(cfgQ[CFG_W-1:ACT_BASE]),
    .pwmIn({pwmInB, pwmInA}), .pwmOut(pwmOutV)
  );

  assign pwmOutA   = pwmOutV[0];
  assign pwmOutB   = pwmOutV[1];
  assign cfgRdData = {{(DATA_W-CFG_W){1'b0}}, cfgQ};

endmodule

// File: rtl/pwm_trip_checker.sv
`timescale 1ns/1ps
module pwm_trip_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [23:0] cfgWrLo,
  input logic [31:0] cfgRdData,
  input logic        pwmInA,
  input logic        pwmInB,
  input logic        pwmOutA,
  input logic        pwmOutB,
  input logic        cntUp,
  input logic        tezStrobe,
  input logic        swCbcStrobe,
  input logic        swOstStrobe,
  input logic        ostClear,
  input logic        ostOn,
  input logic        cbcOn
);

  assert_cfg_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == {8'h00, $past(cfgWrLo)});

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRdData));

  assert_zero_cfg_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData == 32'h0) |-> (pwmOutA == pwmInA && pwmOutB == pwmInB));

  assert_sw_cbc_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    (swCbcStrobe && cfgRdData[0]) |=> cbcOn);

  assert_sw_ost_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (swOstStrobe && cfgRdData[4]) |=> ostOn);

  assert_ost_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ostOn && !ostClear) |=> ostOn);

  assert_cbc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cbcOn && !tezStrobe) |=> cbcOn);

  assert_ost_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ostOn && cbcOn && cntUp && cfgRdData[15:14] == 2'd1) |-> !pwmOutA);

endmodule

bind pwm_trip_unit pwm_trip_checker u_trip_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrLo(cfgWrData[23:0]),
  .cfgRdData(cfgRdData), .pwmInA(pwmInA), .pwmInB(pwmInB),
  .pwmOutA(pwmOutA), .pwmOutB(pwmOutB), .cntUp(cntUp), .tezStrobe(tezStrobe),
  .swCbcStrobe(swCbcStrobe), .swOstStrobe(swOstStrobe), .ostClear(ostClear),
  .ostOn(tripCtl.ostOn), .cbcOn(tripCtl.cbcOn)
);

// File: tb/pwm_trip_unit_bench.sv
`timescale 1ns/1ps
module pwm_trip_unit_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic pwmInA = 1'b0, pwmInB = 1'b0, cntUp = 1'b0, tezStrobe = 1'b0;
  logic [2:0] faultIn = '0;
  logic swCbcStrobe = 1'b0, swOstStrobe = 1'b0, ostClear = 1'b0;
  logic pwmOutA, pwmOutB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_trip_unit u_pwm_trip_unit (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .pwmInA(pwmInA), .pwmInB(pwmInB), .cntUp(cntUp),
    .tezStrobe(tezStrobe), .faultIn(faultIn), .swCbcStrobe(swCbcStrobe),
    .swOstStrobe(swOstStrobe), .ostClear(ostClear),
    .pwmOutA(pwmOutA), .pwmOutB(pwmOutB)
  );

  function automatic logic applyAct(input int code, input logic x);
    case (code)
      0: return x;
      1: return 1'b0;
      2: return 1'b1;
      default: return ~x;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [31:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic clearTrips();
    writeCfg(32'h0);
    ostClear = 1'b1; tezStrobe = 1'b1;
    tick();
    ostClear = 1'b0; tezStrobe = 1'b0;
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7: reset state
    chk("R7 cfg after reset", cfgRdData, 32'h0);
    pwmInA = 1'b1; pwmInB = 1'b0; #1;
    chk("R7 outA pass", {31'h0, pwmOutA}, 32'h1);
    chk("R7 outB pass", {31'h0, pwmOutB}, 32'h0);

    // R12: write/readback, upper bits zero
    writeCfg(32'hFFFF_FFFF);
    chk("R12 readback", cfgRdData, 32'h00FF_FFFF);
    writeCfg(32'hA5C3_5A3C);
    chk("R12 readback2", cfgRdData, 32'h00C3_5A3C);

    // R1 R2: strobes ignored when their enable is 0
    clearTrips();
    writeCfg(32'h00AA_AA00 | 32'hEE);
    swCbcStrobe = 1'b1; tick(); swCbcStrobe = 1'b0;
    pwmInA = 1'b0; pwmInB = 1'b1; #1;
    chk("R1 disabled sw cbc outA", {31'h0, pwmOutA}, 32'h0);
    chk("R1 disabled sw cbc outB", {31'h0, pwmOutB}, 32'h1);
    clearTrips();
    writeCfg(32'h00AA_AA00 | 32'hEE);
    swOstStrobe = 1'b1; tick(); swOstStrobe = 1'b0; #1;
    chk("R2 disabled sw ost outA", {31'h0, pwmOutA}, 32'h0);
    chk("R2 disabled sw ost outB", {31'h0, pwmOutB}, 32'h1);

    // R3 R4 R5 R6: sweep every code in every slot, both directions, all inputs
    for (int slot = 0; slot < 4; slot++) begin
      for (int code = 0; code < 4; code++) begin
        clearTrips();
        writeCfg(32'h11 | (code << (8 + 2 * slot)) | ((3 - code) << (16 + 2 * slot)));
        if (slot >= 2) swOstStrobe = 1'b1; else swCbcStrobe = 1'b1;
        tick();
        swOstStrobe = 1'b0; swCbcStrobe = 1'b0;
        for (int dir = 0; dir < 2; dir++) begin
          for (int in = 0; in < 4; in++) begin
            logic eA, eB;
            cntUp = dir[0]; pwmInA = in[0]; pwmInB = in[1];
            #1;
            eA = ((slot % 2) == dir) ? applyAct(code, in[0]) : in[0];
            eB = ((slot % 2) == dir) ? applyAct(3 - code, in[1]) : in[1];
            chk($sformatf("R3 R4 R6 outA slot%0d code%0d dir%0d in%0d", slot, code, dir, in),
                {31'h0, pwmOutA}, {31'h0, eA});
            chk($sformatf("R3 R5 R6 outB slot%0d code%0d dir%0d in%0d", slot, code, dir, in),
                {31'h0, pwmOutB}, {31'h0, eB});
          end
        end
      end
    end

    // R11 R1 R2: fault mapping and sync latency, A forced high in both directions
    pwmInA = 1'b0; pwmInB = 1'b0; cntUp = 1'b1;
    for (int isOst = 0; isOst < 2; isOst++) begin
      for (int f = 0; f < 3; f++) begin
        int other;
        other = (f + 1) % 3;
        clearTrips();
        writeCfg(isOst ? ((32'h1 << (7 - f)) | 32'hA000) : ((32'h1 << (3 - f)) | 32'hA00));
        faultIn[other] = 1'b1;
        repeat (4) tick();
        faultIn[other] = 1'b0;
        #1;
        chk($sformatf("R1 R2 wrong fault %0d ost%0d", other, isOst), {31'h0, pwmOutA}, 32'h0);
        repeat (3) tick();
        faultIn[f] = 1'b1;
        tick(); #1;
        chk($sformatf("R11 edge1 f%0d ost%0d", f, isOst), {31'h0, pwmOutA}, 32'h0);
        tick(); #1;
        chk($sformatf("R11 edge2 f%0d ost%0d", f, isOst), {31'h0, pwmOutA}, 32'h0);
        tick(); #1;
        chk($sformatf("R11 edge3 f%0d ost%0d", f, isOst), {31'h0, pwmOutA}, 32'h1);
        faultIn[f] = 1'b0;
        repeat (3) tick();
      end
    end

    // R9: cbc clears at tez unless source present
    clearTrips();
    writeCfg(32'h0000_0A09);
    pwmInA = 1'b0;
    swCbcStrobe = 1'b1; tick(); swCbcStrobe = 1'b0;
    repeat (3) tick(); #1;
    chk("R9 cbc held before tez", {31'h0, pwmOutA}, 32'h1);
    tezStrobe = 1'b1; tick(); tezStrobe = 1'b0; #1;
    chk("R9 cbc cleared at tez", {31'h0, pwmOutA}, 32'h0);
    faultIn[0] = 1'b1;
    repeat (3) tick();
    tezStrobe = 1'b1; tick(); tezStrobe = 1'b0; #1;
    chk("R9 cbc kept by live source", {31'h0, pwmOutA}, 32'h1);
    faultIn[0] = 1'b0;
    repeat (3) tick();
    tezStrobe = 1'b1; tick(); tezStrobe = 1'b0; #1;
    chk("R9 cbc cleared after source gone", {31'h0, pwmOutA}, 32'h0);

    // R8: ost latch behaviour
    clearTrips();
    writeCfg(32'h0000_A010);
    swOstStrobe = 1'b1; tick(); swOstStrobe = 1'b0;
    tezStrobe = 1'b1; tick(); tezStrobe = 1'b0; #1;
    chk("R8 ost survives tez", {31'h0, pwmOutA}, 32'h1);
    ostClear = 1'b1; swOstStrobe = 1'b1; tick(); ostClear = 1'b0; swOstStrobe = 1'b0; #1;
    chk("R8 set wins over clear", {31'h0, pwmOutA}, 32'h1);
    ostClear = 1'b1; tick(); ostClear = 1'b0; #1;
    chk("R8 ost cleared", {31'h0, pwmOutA}, 32'h0);

    // R10: ost priority over cbc
    clearTrips();
    writeCfg(32'h0000_4811);
    cntUp = 1'b1; pwmInA = 1'b1;
    swCbcStrobe = 1'b1; tick(); swCbcStrobe = 1'b0;
    pwmInA = 1'b0; #1;
    chk("R10 cbc alone forces high", {31'h0, pwmOutA}, 32'h1);
    pwmInA = 1'b1;
    swOstStrobe = 1'b1; tick(); swOstStrobe = 1'b0; #1;
    chk("R10 ost wins", {31'h0, pwmOutA}, 32'h0);
    ostClear = 1'b1; tick(); ostClear = 1'b0; pwmInA = 1'b0; #1;
    chk("R10 back to cbc action", {31'h0, pwmOutA}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule